// File: doc/BRIEF.md
# Default-Allow Address Range Guard

The block sits in front of one slave address window and rules on each request: allowed or denied. A small set of programmable ranges (the count is a parameter, from 1 to 16) cuts the window into regions at 1 kB granularity. Each range has an inclusive lower bound, an inclusive upper bound and an attribute word. The attribute word holds six permission bits (user and supervisor × read, write, execute) and one allowed-ID bit for each of the 16 privilege IDs.

The rules are permissive by default. An address that falls in no range is allowed. A range whose allowed-ID bit is clear for the requester is skipped and cannot deny. When ranges overlap, every applicable range must grant the access type. A denial, an access to a hole in the guard's own register space, or an illegal access to its registers captures the fault address and a fault status word. No further fault is captured until software writes the clear register. A single interrupt output stays high while a fault is held.

Top module: `rg_guard`

## Requirements
- R1: A request whose address lies inside no range is allowed (`req_allow` = 1), whatever its ID, mode or access type.
- R2: A range matches when lower <= address <= upper. The low 10 bits of the bound registers are ignored and read back as zero, so the upper bound covers its whole last 1 kB page. This holds for every range index up to the last one.
- R3: A matching range whose allowed-ID bit (attribute bit 6+ID) is 0 for the requester's ID does not deny the access.
- R4: Permission bit index = 3×supervisor + kind, where kind is 0 for execute, 1 for write and 2 for read (attribute bits 0..5 are UX, UW, UR, SX, SW, SR). A request is denied when any applicable matching range has that bit at 0.
- R5: On a denied valid request with no fault held, the next cycle holds the fault address = request address and the fault status = {prot-err bit 9, addr-err bit 8, 0, kind bits 6:5, supervisor bit 4, ID bits 3:0}, and `irq` rises.
- R6: While a fault is held, later faults do not change the fault registers. A supervisor write with bit 0 = 1 to word 2 (fault clear) zeroes both fault registers and drops `irq`. When a new fault arrives in the same cycle as the clear, that new fault is captured.
- R7: Config access to a word that is not a register sets the address-error flag (bit 8). The captured address is the config word address and the kind is 1 for a write or 2 for a read. Valid words are 0 (fault address, read-only), 1 (fault status, read-only), 2 (fault clear, write-only), and 64+4i, 65+4i, 66+4i for the lower bound, upper bound and attribute of range i.
- R8: A user-mode config access, a write to a read-only register or a read of the clear register sets the protection-error flag (bit 9), and any write in it is discarded.
- R9: After reset all ranges are zero with an attribute of 0, every request is allowed, the fault registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented |
| req_addr | input | ADDR_W | Request byte address |
| req_pid | input | 4 | Requester privilege ID |
| req_sup | input | 1 | 1 = supervisor, 0 = user |
| req_kind | input | 2 | 0 execute, 1 write, 2 read |
| req_allow | output | 1 | Combinational verdict for the current request |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | CA_W | Register word address |
| cfg_wdata | input | 32 | Write data |
| cfg_pid | input | 4 | Privilege ID of the register accessor |
| cfg_sup | input | 1 | Mode of the register accessor |
| cfg_rdata | output | 32 | Combinational read data, 0 when the read is refused |
| irq | output | 1 | Combined address/protection error interrupt |

## Verification
The assertions assume that `req_kind` is never 3 and that every input is free of X and Z after reset. The properties on clearing also assume that no request is denied in the same cycle as a clear write. The bench drives only the three defined kinds and applies a single operation per task. It always issues a clear as a lone config write with `req_valid` low, so these assumptions hold on every cycle it drives.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int PID_W      = 4;
    localparam int NUM_PID    = 16;
    localparam int PERM_W     = 6;
    localparam int ATTR_USED  = PERM_W + NUM_PID;
    localparam int FSTAT_W    = 10;

    localparam int FADDR_OFS  = 0;
    localparam int FSTAT_OFS  = 1;
    localparam int FCLR_OFS   = 2;
    localparam int RANGE_BASE = 64;

    localparam int FS_SUP     = 4;
    localparam int FS_AERR    = 8;
    localparam int FS_PERR    = 9;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FADDR,
        SEL_FSTAT,
        SEL_FCLR,
        SEL_LO,
        SEL_HI,
        SEL_ATTR
    } sel_e;

    // bit position of the permission that governs one access
    function automatic logic [2:0] perm_idx(input logic sup, input logic [1:0] kind);
        return {1'b0, kind} + (sup ? 3'd3 : 3'd0);
    endfunction

endpackage

// File: rtl/rg_reg_decode.sv
module rg_reg_decode
    import rg_pkg::*;
#(
    parameter int NR    = 16,
    parameter int CA_W  = 8,
    parameter int IDX_W = 4
) (
    input  logic [CA_W-1:0]  addr,
    output sel_e             sel,
    output logic [IDX_W-1:0] idx
);

    localparam int RANGE_END = RANGE_BASE + 4 * NR;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (addr == CA_W'(FADDR_OFS)) begin
            sel = SEL_FADDR;
        end else if (addr == CA_W'(FSTAT_OFS)) begin
            sel = SEL_FSTAT;
        end else if (addr == CA_W'(FCLR_OFS)) begin
            sel = SEL_FCLR;
        end else if (int'(addr) >= RANGE_BASE && int'(addr) < RANGE_END) begin
            idx = IDX_W'((int'(addr) - RANGE_BASE) >> 2);
            case (addr[1:0])
                2'd0:    sel = SEL_LO;
                2'd1:    sel = SEL_HI;
                2'd2:    sel = SEL_ATTR;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/rg_range_check.sv
module rg_range_check
    import rg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN   = 10
) (
    input  logic [ADDR_W-GRAN-1:0] lo,
    input  logic [ADDR_W-GRAN-1:0] hi,
    input  logic [ATTR_USED-1:0]   attr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [PID_W-1:0]       pid,
    input  logic [2:0]             pidx,
    output logic                   applies,
    output logic                   grants
);

    logic hit;

    always_comb begin
        hit     = (addr >= {lo, {GRAN{1'b0}}}) && (addr <= {hi, {GRAN{1'b1}}});
        // a range with the requester's ID bit clear never takes part
        applies = hit && attr[PERM_W + int'(pid)];
        grants  = attr[pidx];
    end

endmodule

// File: rtl/rg_guard.sv
module rg_guard
    import rg_pkg::*;
#(
    parameter int NR     = 16,
    parameter int ADDR_W = 32,
    parameter int GRAN   = 10,
    parameter int CA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_pid,
    input  logic              req_sup,
    input  logic [1:0]        req_kind,
    output logic              req_allow,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_pid,
    input  logic              cfg_sup,
    output logic [31:0]       cfg_rdata,
    output logic              irq
);

    localparam int PG_W  = ADDR_W - GRAN;
    localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1;

    typedef struct {
        logic [PG_W-1:0]    lo   [NR];
        logic [PG_W-1:0]    hi   [NR];
        logic [31:0]        attr [NR];
        logic [ADDR_W-1:0]  faddr;
        logic [FSTAT_W-1:0] fstat;
    } state_t;

    state_t q, d;

    sel_e             sel;
    logic [IDX_W-1:0] cidx;
    logic [NR-1:0]    app_vec;
    logic [NR-1:0]    grant_vec;
    logic [2:0]       pidx;
    logic             deny;
    logic             busy;
    logic             aerr, perr, ro_wr, wo_rd, wr_ok, rd_ok, clr, req_fault;
    logic [ADDR_W-1:0] flt_addr;

    rg_reg_decode #(.NR(NR), .CA_W(CA_W), .IDX_W(IDX_W)) i_dec (
        .addr (cfg_addr),
        .sel  (sel),
        .idx  (cidx)
    );

    assign pidx = perm_idx(req_sup, req_kind);

    for (genvar g = 0; g < NR; g++) begin : g_rng
        rg_range_check #(.ADDR_W(ADDR_W), .GRAN(GRAN)) i_chk (
            .lo      (q.lo[g]),
            .hi      (q.hi[g]),
            .attr    (q.attr[g][ATTR_USED-1:0]),
            .addr    (req_addr),
            .pid     (req_pid),
            .pidx    (pidx),
            .applies (app_vec[g]),
            .grants  (grant_vec[g])
        );
    end

    // every applicable range must grant; no applicable range means allow
    assign deny      = |(app_vec & ~grant_vec);
    assign req_allow = !deny;
    assign busy      = q.fstat[FS_AERR] | q.fstat[FS_PERR];
    assign irq       = busy;
    assign flt_addr  = q.faddr;

    always_comb begin
        d         = q;
        cfg_rdata = '0;

        aerr  = cfg_en && (sel == SEL_NONE);
        ro_wr = cfg_we && (sel == SEL_FADDR || sel == SEL_FSTAT);
        wo_rd = !cfg_we && (sel == SEL_FCLR);
        perr  = cfg_en && !aerr && (!cfg_sup || ro_wr || wo_rd);
        wr_ok = cfg_en && cfg_we && !aerr && !perr;
        rd_ok = cfg_en && !cfg_we && !aerr && !perr;
        clr   = wr_ok && (sel == SEL_FCLR) && cfg_wdata[0];

        if (rd_ok) begin
            case (sel)
                SEL_FADDR: cfg_rdata = 32'(q.faddr);
                SEL_FSTAT: cfg_rdata = 32'(q.fstat);
                SEL_LO:    cfg_rdata = 32'({q.lo[cidx], {GRAN{1'b0}}});
                SEL_HI:    cfg_rdata = 32'({q.hi[cidx], {GRAN{1'b0}}});
                SEL_ATTR:  cfg_rdata = q.attr[cidx];
                default:   cfg_rdata = '0;
            endcase
        end

        if (wr_ok) begin
            case (sel)
                SEL_LO:   d.lo[cidx]   = cfg_wdata[ADDR_W-1:GRAN];
                SEL_HI:   d.hi[cidx]   = cfg_wdata[ADDR_W-1:GRAN];
                SEL_ATTR: d.attr[cidx] = cfg_wdata;
                default:  ;
            endcase
        end

        if (clr) begin
            d.faddr = '0;
            d.fstat = '0;
        end

        // a denied request outranks a register fault in the same cycle
        req_fault = req_valid && deny;
        if ((req_fault || aerr || perr) && (!busy || clr)) begin
            if (req_fault) begin
                d.faddr = req_addr;
                d.fstat = {1'b1, 1'b0, 1'b0, req_kind, req_sup, req_pid};
            end else begin
                d.faddr = ADDR_W'(cfg_addr);
                d.fstat = {perr, aerr, 1'b0, (cfg_we ? 2'd1 : 2'd2), cfg_sup, cfg_pid};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lo    <= '{default: '0};
            q.hi    <= '{default: '0};
            q.attr  <= '{default: '0};
            q.faddr <= '0;
            q.fstat <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rg_guard_chk.sv
module rg_guard_chk
    import rg_pkg::*;
#(
    parameter int NR     = 16,
    parameter int ADDR_W = 32,
    parameter int CA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_allow,
    input logic              cfg_en,
    input logic              cfg_we,
    input logic [CA_W-1:0]   cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_sup,
    input logic              irq,
    input logic [NR-1:0]     app_vec,
    input logic [ADDR_W-1:0] flt_addr
);

    logic clr_wr;
    assign clr_wr = cfg_en && cfg_we && cfg_sup && (cfg_addr == CA_W'(FCLR_OFS)) && cfg_wdata[0];

    // R3 / R4: a denial needs at least one range that applies to the requester
    p_deny_needs_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_allow |-> (|app_vec));

    // R1: the verdict is always a defined level
    p_allow_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$isunknown(req_allow));

    // R5: a denied request with nothing held raises the interrupt
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_allow && !irq |=> irq);

    // R6: a held fault keeps its address until cleared
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_wr |=> irq && $stable(flt_addr));

    // R6: a clear with no competing denial drops the interrupt
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !(req_valid && !req_allow) |=> !irq);

endmodule

bind rg_guard rg_guard_chk #(.NR(NR), .ADDR_W(ADDR_W), .CA_W(CA_W)) i_rg_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_allow (req_allow),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_sup   (cfg_sup),
    .irq       (irq),
    .app_vec   (app_vec),
    .flt_addr  (flt_addr)
);

// File: tb/test_rg_guard.sv
module test_rg_guard;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [31:0] req_addr = 0;
    logic [3:0]  req_pid = 0;
    logic        req_sup = 0;
    logic [1:0]  req_kind = 0;
    logic        req_allow;
    logic        cfg_en = 0;
    logic        cfg_we = 0;
    logic [7:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [3:0]  cfg_pid = 0;
    logic        cfg_sup = 0;
    logic [31:0] cfg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // 8 time units per cycle: 125 MHz at a 1 ns unit
    always #4 clk = ~clk;

    rg_guard i_rg_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_pid(req_pid),
        .req_sup(req_sup), .req_kind(req_kind), .req_allow(req_allow),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_pid(cfg_pid), .cfg_sup(cfg_sup),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    localparam logic [1:0] K_EX = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

    function automatic logic [7:0] slot(input int r, input int s);
        return 8'(64 + 4 * r + s);
    endfunction

    function automatic logic [31:0] attr(input logic [15:0] ids, input logic [5:0] perms);
        return {10'b0, ids, perms};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] v, input logic sup, input logic [3:0] pid);
        @(negedge clk);
        cfg_en = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = v; cfg_sup = sup; cfg_pid = pid;
        @(negedge clk);
        cfg_en = 0; cfg_we = 0;
    endtask

    task automatic cfg_rd(input logic [7:0] a, input logic sup, input logic [3:0] pid, output logic [31:0] v);
        @(negedge clk);
        cfg_en = 1; cfg_we = 0; cfg_addr = a; cfg_sup = sup; cfg_pid = pid;
        #1 v = cfg_rdata;
        @(negedge clk);
        cfg_en = 0;
    endtask

    task automatic clear_fault();
        cfg_wr(8'd2, 32'd1, 1'b1, 4'd0);
    endtask

    task automatic probe(input logic [31:0] a, input logic [3:0] pid, input logic sup,
                         input logic [1:0] kind, input logic exp, input string req);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_pid = pid; req_sup = sup; req_kind = kind;
        #1 chk(req, 32'(req_allow), 32'(exp), $sformatf("allow @0x%0h pid %0d", a, pid));
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R9", 32'(irq), 0, "irq after reset");
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R9", v, 0, "fault status after reset");
        cfg_rd(slot(0, 2), 1'b1, 4'd0, v);
        chk("R9", v, 0, "range0 attr after reset");
        probe(32'h1400, 4'd2, 1'b0, K_RD, 1'b1, "R9");
    endtask

    task automatic t_unmatched();
        cfg_wr(slot(0, 0), 32'h1000, 1'b1, 4'd0);
        cfg_wr(slot(0, 1), 32'h1FFF, 1'b1, 4'd0);
        cfg_wr(slot(0, 2), attr(16'h0004, 6'h00), 1'b1, 4'd0);
        probe(32'h3000, 4'd2, 1'b1, K_WR, 1'b1, "R1");
        probe(32'h0FFF, 4'd2, 1'b0, K_RD, 1'b1, "R1");
        chk("R1", 32'(irq), 0, "no fault on unmatched");
    endtask

    task automatic t_gran_and_capture();
        logic [31:0] v;
        cfg_rd(slot(0, 1), 1'b1, 4'd0, v);
        chk("R2", v, 32'h1C00, "upper bound low bits dropped");
        probe(32'h2000, 4'd2, 1'b1, K_EX, 1'b1, "R2");
        probe(32'h1FFF, 4'd2, 1'b1, K_EX, 1'b0, "R2");
        chk("R5", 32'(irq), 1, "irq after deny");
        cfg_rd(8'd0, 1'b1, 4'd0, v);
        chk("R5", v, 32'h1FFF, "fault address");
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R5", v, 32'h212, "fault status");
    endtask

    task automatic t_inhibit_clear();
        logic [31:0] v;
        probe(32'h1400, 4'd2, 1'b0, K_RD, 1'b0, "R6");
        cfg_rd(8'd0, 1'b1, 4'd0, v);
        chk("R6", v, 32'h1FFF, "held address not overwritten");
        clear_fault();
        chk("R6", 32'(irq), 0, "irq after clear");
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R6", v, 0, "status after clear");
        probe(32'h1400, 4'd2, 1'b0, K_RD, 1'b0, "R6");
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R6", v, 32'h242, "new capture after clear");
        clear_fault();
    endtask

    task automatic t_skip();
        probe(32'h1400, 4'd5, 1'b1, K_WR, 1'b1, "R3");
        chk("R3", 32'(irq), 0, "skipped range raised no fault");
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        cfg_wr(slot(1, 0), 32'h1000, 1'b1, 4'd0);
        cfg_wr(slot(1, 1), 32'h3FFF, 1'b1, 4'd0);
        cfg_wr(slot(1, 2), attr(16'h0008, 6'h3F), 1'b1, 4'd0);
        cfg_wr(slot(0, 2), attr(16'h000C, 6'h20), 1'b1, 4'd0);
        probe(32'h1800, 4'd3, 1'b1, K_RD, 1'b1, "R4");
        probe(32'h1800, 4'd3, 1'b1, K_WR, 1'b0, "R4");
        clear_fault();
        probe(32'h2800, 4'd3, 1'b1, K_WR, 1'b1, "R4");
        probe(32'h1800, 4'd3, 1'b0, K_RD, 1'b0, "R4");
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R4", v, 32'h243, "status for user read denial");
        clear_fault();
        cfg_wr(slot(15, 0), 32'h8000, 1'b1, 4'd0);
        cfg_wr(slot(15, 1), 32'h83FF, 1'b1, 4'd0);
        cfg_wr(slot(15, 2), attr(16'h0008, 6'h00), 1'b1, 4'd0);
        probe(32'h83FF, 4'd3, 1'b1, K_RD, 1'b0, "R2");
        probe(32'h8400, 4'd3, 1'b1, K_RD, 1'b1, "R2");
        clear_fault();
    endtask

    task automatic t_addr_err();
        logic [31:0] v;
        cfg_rd(8'd3, 1'b1, 4'd7, v);
        chk("R7", 32'(irq), 1, "irq on hole read");
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R7", v, 32'h157, "status for hole read");
        clear_fault();
        cfg_wr(slot(0, 3), 32'hFFFF, 1'b1, 4'd7);
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R7", v, 32'h137, "status for hole write");
        cfg_rd(8'd0, 1'b1, 4'd0, v);
        chk("R7", v, 32'd67, "address for hole write");
        clear_fault();
    endtask

    task automatic t_prot();
        logic [31:0] v;
        cfg_wr(slot(0, 0), 32'h5000, 1'b0, 4'd4);
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R8", v, 32'h224, "status for user write");
        cfg_rd(slot(0, 0), 1'b1, 4'd0, v);
        chk("R8", v, 32'h1000, "user write discarded");
        cfg_wr(8'd2, 32'd1, 1'b0, 4'd4);
        chk("R8", 32'(irq), 1, "user clear refused");
        clear_fault();
        cfg_wr(8'd0, 32'h1234, 1'b1, 4'd7);
        cfg_rd(8'd1, 1'b1, 4'd0, v);
        chk("R8", v, 32'h237, "status for read-only write");
        clear_fault();
        chk("R8", 32'(irq), 0, "irq after final clear");
    endtask

    initial begin
        #5000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_unmatched();
        t_gran_and_capture();
        t_inhibit_clear();
        t_skip();
        t_overlap();
        t_addr_err();
        t_prot();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule